// File: doc/BRIEF.md
# Serial Frame Driver for a 20-bit Audio Converter

This block turns a stream of signed 20-bit samples into the three-wire serial form that a 20-bit audio converter expects. It produces a bit clock, a data line and a latch-enable line. Samples arrive over a valid/ready handshake and are taken once per frame. Each frame is a slot of 24 bit-clock periods. The first four positions of a slot carry zero padding. The sample then follows in two's complement, most significant bit first, so its least significant bit is the last bit shifted before the latch.

The bit clock is the system clock divided by an even ratio. The ratio is twice a programmable half-period. A compile-time floor, derived from the system clock frequency and the highest bit rate the converter accepts, stops the bit clock from running too fast.

The data line and the latch-enable line change only on bit-clock falling edges, because the converter samples on rising edges. Latch enable drops on the falling edge that opens a new slot. That edge follows the rising edge that captured the previous slot's least significant bit. Latch enable stays low for two bit-clock periods and is high for the other 22. If no sample is waiting when a frame begins, the previous sample is sent again and an underrun flag is raised for that frame.

Top module: `dac_frame_drv`

## Requirements
- R1: Consecutive latch-enable falling edges are 24 bit-clock periods apart, which is 48 times the effective half-period in system clock cycles.
- R2: The serial data output changes only in the system clock cycle where the bit clock goes from 1 to 0.
- R3: The 24 bits present on the data line at the 24 rising bit-clock edges of a slot are, in order, four zeros and then sample bits 19 down to 0. The captured slot word therefore equals {4'b0000, sample}.
- R4: Latch enable changes only where the bit clock falls. It goes low at the slot boundary and stays low across exactly 2 rising bit-clock edges, then stays high across the remaining 22.
- R5: The bit clock stays at each level for max(half_sel_i, MIN_HALF) system clock cycles. MIN_HALF is ceil(CLK_HZ / (2 × BCLK_MAX_HZ)) and is at least 1; with the defaults it is 2, so settings 0 and 1 behave like 2.
- R6: s_ready_o is high for exactly one system clock cycle per frame, in the cycle whose clock edge opens the new slot. A sample is taken only when s_valid_i and s_ready_o are both high; s_valid_i at any other time has no effect on the data sent.
- R7: A sample taken at a slot boundary is sent in the slot that this boundary opens, and it is latched at the next latch-enable falling edge.
- R8: If s_valid_i is low while s_ready_o is high, the slot that opens resends the last taken sample and underrun_o reads 1 for that slot. A slot that takes a new sample shows underrun_o = 0.
- R9: While rst is high, bclk_o = 0, le_o = 1, sdata_o = 0, s_ready_o = 0 and underrun_o = 0, and the held sample is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_sel_i | input | DIV_W (8) | Bit-clock half-period in system clock cycles, floored at MIN_HALF |
| s_valid_i | input | 1 | A sample is offered |
| s_data_i | input | SAMPLE_BITS (20) | Signed sample, two's complement |
| s_ready_o | output | 1 | One-cycle pulse per frame; the sample is taken when valid is also high |
| bclk_o | output | 1 | Bit clock to the converter |
| sdata_o | output | 1 | Serial data, changes on bit-clock falling edges |
| le_o | output | 1 | Latch enable; its falling edge transfers the last 20 bits |
| underrun_o | output | 1 | The current slot repeats the previous sample |

## Verification
The serial output is reassembled from the pins on every rising bit-clock edge and compared, at each latch-enable fall, against samples chosen to separate failure modes. Positive and negative full scale catch a dropped or inverted sign bit. The single-LSB value and the all-ones pattern catch an off-by-one slot alignment, where a pad bit would leak into the word. Alternating patterns catch swapped bit order.

A back-to-back stream tells correct one-per-frame acceptance apart from skipped or doubled frames. A starved stream and a valid pulse that misses the ready window both show whether the previous word is repeated and flagged. Sweeping the divider through values above, at and below the floor separates the real period from the clamped one.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

  localparam int unsigned SAMPLE_BITS_DEF = 20;
  localparam int unsigned SLOT_BITS_DEF   = 24;
  localparam int unsigned LE_LOW_DEF      = 2;

  // One-cycle strobes marking the system clock edge where the bit clock moves.
  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_evt_t;

  // Smallest half-period that keeps the bit rate at or below max_hz.
  function automatic int unsigned min_half_for(longint unsigned clk_hz,
                                               longint unsigned max_hz);
    longint unsigned q;
    q = (clk_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (q < 1) ? 1 : int'(q);
  endfunction

  // Slot position that follows p in a slot of len positions.
  function automatic int unsigned wrap_next(int unsigned p, int unsigned len);
    return (p >= len - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/dac_frame_bclk.sv
module dac_frame_bclk
  import dac_frame_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_sel,
  output logic             bclk,
  output bclk_evt_t        evt
);

  localparam int unsigned FLOOR_W = $clog2(MIN_HALF + 1);
  localparam int unsigned CNT_W   = (DIV_W > FLOOR_W) ? DIV_W : FLOOR_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_eff;
  logic             bclk_q;
  logic             tick;

  // Clamp the requested half-period so the bit rate stays legal.
  function automatic logic [CNT_W-1:0] eff_half(logic [DIV_W-1:0] sel);
    if (CNT_W'(sel) < CNT_W'(MIN_HALF)) return CNT_W'(MIN_HALF);
    return CNT_W'(sel);
  endfunction

  assign half_eff = eff_half(half_sel);
  assign tick     = (cnt_q >= half_eff - CNT_W'(1));
  assign evt.rise = tick & ~bclk_q;
  assign evt.fall = tick & bclk_q;
  assign bclk     = bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dac_frame_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = 24,
  parameter int unsigned LE_LOW_BITS = 2,
  localparam int unsigned POS_W      = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  output logic [POS_W-1:0] pos,
  output logic             frame_start,
  output logic             le
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  logic             le_q;

  // Latch enable is low only at the first LE_LOW_BITS positions of a slot.
  function automatic logic le_level(logic [POS_W-1:0] p);
    return (int'(p) >= int'(LE_LOW_BITS));
  endfunction

  assign pos_nx      = POS_W'(wrap_next(int'(pos_q), SLOT_BITS));
  assign frame_start = fall && (int'(pos_q) == int'(SLOT_BITS) - 1);
  assign pos         = pos_q;
  assign le          = le_q;

  // Reset parks inside an idle slot with latch enable high, so the first
  // boundary arrives only after the high phase has run its full length.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_W'(LE_LOW_BITS);
      le_q  <= 1'b1;
    end else if (fall) begin
      pos_q <= pos_nx;
      le_q  <= le_level(pos_nx);
    end
  end

endmodule

// File: rtl/dac_frame_src.sv
module dac_frame_src #(
  parameter int unsigned SAMPLE_BITS = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   s_valid,
  input  logic [SAMPLE_BITS-1:0] s_data,
  output logic                   s_ready,
  output logic [SAMPLE_BITS-1:0] word,
  output logic                   underrun
);

  logic [SAMPLE_BITS-1:0] word_q;
  logic                   under_q;
  logic                   take;

  assign s_ready  = frame_start;
  assign take     = frame_start & s_valid;
  assign word     = word_q;
  assign underrun = under_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      under_q <= 1'b0;
    end else if (frame_start) begin
      under_q <= ~s_valid;
      if (take) word_q <= s_data;
    end
  end

endmodule

// File: rtl/dac_frame_bitout.sv
module dac_frame_bitout
  import dac_frame_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS = 20,
  parameter int unsigned SLOT_BITS   = 24,
  localparam int unsigned POS_W      = $clog2(SLOT_BITS),
  localparam int unsigned PAD_BITS   = SLOT_BITS - SAMPLE_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fall,
  input  logic [POS_W-1:0]       pos,
  input  logic [SAMPLE_BITS-1:0] word,
  output logic                   sdata
);

  logic [POS_W-1:0] pos_nx;
  logic             sd_q;

  // Padding first, then the sample MSB first, so the LSB closes the slot.
  function automatic logic slot_bit(logic [SAMPLE_BITS-1:0] w, logic [POS_W-1:0] p);
    logic [SAMPLE_BITS-1:0] sh;
    if (int'(p) < int'(PAD_BITS)) return 1'b0;
    sh = w >> (int'(SLOT_BITS) - 1 - int'(p));
    return sh[0];
  endfunction

  assign pos_nx = POS_W'(wrap_next(int'(pos), SLOT_BITS));
  assign sdata  = sd_q;

  // At a slot boundary the next position is a pad bit, so the word
  // register loading at the same edge never reaches the line early.
  always_ff @(posedge clk) begin
    if (rst)       sd_q <= 1'b0;
    else if (fall) sd_q <= slot_bit(word, pos_nx);
  end

endmodule

// File: rtl/dac_frame_drv.sv
module dac_frame_drv
  import dac_frame_pkg::*;
#(
  parameter int unsigned     SAMPLE_BITS = SAMPLE_BITS_DEF,
  parameter int unsigned     SLOT_BITS   = SLOT_BITS_DEF,
  parameter int unsigned     LE_LOW_BITS = LE_LOW_DEF,
  parameter int unsigned     DIV_W       = 8,
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned BCLK_MAX_HZ = 25_000_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIV_W-1:0]       half_sel_i,
  input  logic                   s_valid_i,
  input  logic [SAMPLE_BITS-1:0] s_data_i,
  output logic                   s_ready_o,
  output logic                   bclk_o,
  output logic                   sdata_o,
  output logic                   le_o,
  output logic                   underrun_o
);

  localparam int unsigned MIN_HALF = min_half_for(CLK_HZ, BCLK_MAX_HZ);
  localparam int unsigned POS_W    = $clog2(SLOT_BITS);

  // Internal events, named so the bound checker can see them.
  bclk_evt_t              bclk_evt;
  logic                   bclk_fall;
  logic                   bclk_rise;
  logic [POS_W-1:0]       slot_pos;
  logic                   slot_start;
  logic [SAMPLE_BITS-1:0] held_word;

  assign bclk_fall = bclk_evt.fall;
  assign bclk_rise = bclk_evt.rise;

  dac_frame_bclk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_bclk (
    .clk      (clk),
    .rst      (rst),
    .half_sel (half_sel_i),
    .bclk     (bclk_o),
    .evt      (bclk_evt)
  );

  dac_frame_seq #(.SLOT_BITS(SLOT_BITS), .LE_LOW_BITS(LE_LOW_BITS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fall        (bclk_fall),
    .pos         (slot_pos),
    .frame_start (slot_start),
    .le          (le_o)
  );

  dac_frame_src #(.SAMPLE_BITS(SAMPLE_BITS)) u_src (
    .clk         (clk),
    .rst         (rst),
    .frame_start (slot_start),
    .s_valid     (s_valid_i),
    .s_data      (s_data_i),
    .s_ready     (s_ready_o),
    .word        (held_word),
    .underrun    (underrun_o)
  );

  dac_frame_bitout #(.SAMPLE_BITS(SAMPLE_BITS), .SLOT_BITS(SLOT_BITS)) u_bit (
    .clk   (clk),
    .rst   (rst),
    .fall  (bclk_fall),
    .pos   (slot_pos),
    .word  (held_word),
    .sdata (sdata_o)
  );

endmodule

// File: rtl/dac_frame_drv_chk.sv
module dac_frame_drv_chk #(
  parameter int unsigned SAMPLE_BITS = 20,
  parameter int unsigned SLOT_BITS   = 24,
  parameter int unsigned MIN_HALF    = 2,
  localparam int unsigned POS_W      = $clog2(SLOT_BITS),
  localparam int unsigned PAD_BITS   = SLOT_BITS - SAMPLE_BITS
) (
  input logic             clk,
  input logic             rst,
  input logic             bclk,
  input logic             rise,
  input logic             fall,
  input logic [POS_W-1:0] pos,
  input logic             slot_start,
  input logic             le,
  input logic             sdata,
  input logic             ready,
  input logic             valid,
  input logic             underrun
);

  // Length of the bit clock's previous level, saturating.
  logic [15:0] run_q;
  logic        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 16'(MIN_HALF);
      last_q <= 1'b0;
    end else if (bclk != last_q) begin
      run_q  <= 16'd1;
      last_q <= bclk;
    end else if (run_q != 16'hFFFF) begin
      run_q  <= run_q + 16'd1;
    end
  end

  a_r5_bclk_min_half: assert property (@(posedge clk) disable iff (rst)
    (bclk != last_q) |-> (run_q >= 16'(MIN_HALF)));

  a_r5_rise_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |-> $past(rise));

  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sdata));

  a_r4_le_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(le));

  a_r4_le_drop_at_slot: assert property (@(posedge clk) disable iff (rst)
    $fell(le) |-> $past(slot_start));

  a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(pos) < int'(PAD_BITS)) |-> !sdata);

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r6_ready_at_fall: assert property (@(posedge clk) disable iff (rst)
    ready |-> (fall && bclk));

  a_r8_underrun_set: assert property (@(posedge clk) disable iff (rst)
    (ready && !valid) |=> underrun);

  a_r8_underrun_clear: assert property (@(posedge clk) disable iff (rst)
    (ready && valid) |=> !underrun);

endmodule

bind dac_frame_drv dac_frame_drv_chk #(
  .SAMPLE_BITS (SAMPLE_BITS),
  .SLOT_BITS   (SLOT_BITS),
  .MIN_HALF    (MIN_HALF)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bclk       (bclk_o),
  .rise       (bclk_rise),
  .fall       (bclk_fall),
  .pos        (slot_pos),
  .slot_start (slot_start),
  .le         (le_o),
  .sdata      (sdata_o),
  .ready      (s_ready_o),
  .valid      (s_valid_i),
  .underrun   (underrun_o)
);

// File: tb/dac_frame_drv_tb.sv
module dac_frame_drv_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  half_sel = 8'd2;
  logic        s_valid = 1'b0;
  logic [19:0] s_data = '0;
  logic        s_ready, bclk, sdata, le, underrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dac_frame_drv u_dut (
    .clk(clk), .rst(rst), .half_sel_i(half_sel), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(s_ready), .bclk_o(bclk), .sdata_o(sdata),
    .le_o(le), .underrun_o(underrun)
  );

  // Pin monitor: rebuilds slots and measures timing at the falling clock.
  int        cyc = 0;
  logic      p_bclk = 1'b0, p_le = 1'b1, p_sd = 1'b0;
  logic [23:0] cap = '0;
  logic [23:0] lat_log [256];
  int falls = 0, last_rise = 0, per = 0, last_fall = 0, frame_len = 0;
  int hi_run = 0, lo_run = 0, hi_last = 0, lo_last = 0;
  int rdy_cnt = 0, rdy_last = 0, viol = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (s_ready) rdy_cnt++;
      if ((sdata != p_sd || le != p_le) && !(p_bclk && !bclk)) viol++;
      if (bclk && !p_bclk) begin
        cap = {cap[22:0], sdata};
        per = cyc - last_rise;
        last_rise = cyc;
        if (le) hi_run++; else lo_run++;
      end
      if (p_le && !le) begin
        lat_log[falls % 256] = cap;
        falls++;
        frame_len = cyc - last_fall;
        last_fall = cyc;
        hi_last = hi_run; hi_run = 0;
        rdy_last = rdy_cnt; rdy_cnt = 0;
      end
      if (!p_le && le) begin
        lo_last = lo_run; lo_run = 0;
      end
    end
    p_bclk = bclk; p_le = le; p_sd = sdata;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wait_falls(int n);
    while (falls < n) settle();
  endtask

  // Offers s, waits for the handshake; returns the log index of its slot.
  task automatic push(logic [19:0] s, output int idx);
    s_data = s; s_valid = 1'b1;
    settle();
    while (!s_ready) settle();
    idx = falls + 1;
    @(posedge clk); #1;
    check(underrun == 1'b0, "R8 underrun clear on take", int'(underrun), 0);
  endtask

  task automatic t_reset();
    repeat (5) @(posedge clk);
    settle();
    check(bclk == 0 && le == 1 && sdata == 0, "R9 reset outputs",
          int'({bclk, le, sdata}), 3'b010);
    check(s_ready == 0 && underrun == 0, "R9 reset handshake",
          int'({s_ready, underrun}), 0);
    rst = 1'b0;
  endtask

  task automatic t_stream();
    logic [19:0] v [7];
    int idx [7];
    v = '{20'h7FFFF, 20'h80000, 20'h00001, 20'hFFFFF, 20'hA5A5A, 20'h5A5A5, 20'h00000};
    for (int i = 0; i < 7; i++) push(v[i], idx[i]);
    s_valid = 1'b0;
    wait_falls(idx[6] + 1);
    for (int i = 0; i < 7; i++)
      check(lat_log[idx[i] % 256] == {4'h0, v[i]}, "R3 R7 slot word",
            int'(lat_log[idx[i] % 256]), int'({4'h0, v[i]}));
    check(rdy_last == 1, "R6 one ready per frame", rdy_last, 1);
  endtask

  task automatic t_underrun();
    int i0, i1;
    push(20'h12345, i0);
    s_valid = 1'b0;
    wait_falls(i0 + 1);
    check(underrun == 1'b1, "R8 underrun raised", int'(underrun), 1);
    wait_falls(i0 + 2);
    check(lat_log[i0 % 256] == 24'h012345, "R7 taken word", int'(lat_log[i0 % 256]), 24'h012345);
    check(lat_log[(i0 + 1) % 256] == 24'h012345, "R8 repeated word",
          int'(lat_log[(i0 + 1) % 256]), 24'h012345);
    push(20'hC0FFE, i1);
    s_valid = 1'b0;
    wait_falls(i1 + 1);
    check(lat_log[i1 % 256] == 24'h0C0FFE, "R8 recovery word", int'(lat_log[i1 % 256]), 24'h0C0FFE);
  endtask

  task automatic t_ignore();
    int f0;
    wait_falls(falls + 1);
    f0 = falls;
    s_data = 20'h3C3C3; s_valid = 1'b1;
    repeat (10) settle();
    s_valid = 1'b0; s_data = '0;
    wait_falls(f0 + 2);
    check(lat_log[f0 % 256] == lat_log[(f0 - 1) % 256], "R6 valid off-window ignored",
          int'(lat_log[f0 % 256]), int'(lat_log[(f0 - 1) % 256]));
    check(underrun == 1'b1, "R8 underrun after missed window", int'(underrun), 1);
  endtask

  task automatic t_timing(int h);
    wait_falls(falls + 2);
    check(per == 2 * h, "R5 bit clock period", per, 2 * h);
    check(frame_len == 48 * h, "R1 frame length", frame_len, 48 * h);
    check(lo_last == 2, "R4 latch low span", lo_last, 2);
    check(hi_last == 22, "R4 latch high span", hi_last, 22);
    check(viol == 0, "R2 R4 changes only on falling bit clock", viol, 0);
  endtask

  task automatic t_divider();
    half_sel = 8'd3; t_timing(3);
    half_sel = 8'd0; t_timing(2);
    half_sel = 8'd1; t_timing(2);
    half_sel = 8'd2; t_timing(2);
  endtask

  initial begin
    t_reset();
    t_timing(2);
    t_stream();
    t_underrun();
    t_ignore();
    t_divider();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule